// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesizer

This block is the digital half of a clock synthesizer. A wide phase accumulator adds a frequency tuning word on every clock and wraps modulo its full range. The top bits of the accumulator form a phase index, and that index is turned into a narrow unsigned code for an external resistor-ladder DAC. The DAC, its reconstruction filter and the comparator are outside the block.

Three waveforms are available. The sine is read from a table stored around mid-scale. The sawtooth takes the phase bits straight from the accumulator. The triangle inverts the phase bits on every other accumulator period, so it runs at half the accumulator frequency. A change of waveform takes effect only when the accumulator wraps, so the output never shows a partial period. A one-clock strobe marks each wrap.

Top module: `dds_wavegen`

## Requirements
- R1: On every clock the 32-bit phase accumulator advances by `ftw`, modulo 2^32. A sawtooth run with `ftw` = 2^27 makes this visible at the output.
- R2: `wrap` is high for exactly the cycle that follows an addition that carried out of the accumulator. It never rises while `ftw` is 0, and it is high on every second cycle when `ftw` = 2^31.
- R3: With `wave_sel` = 0 (sine), the code is round(15.5 + 15.5·sin(2πk/256)), clamped to 0..31, where k is accumulator bits [31:24]. Three sample points: k=0 gives 16, k=64 gives 31 and k=192 gives 0.
- R4: With `wave_sel` = 1 or 3 (sawtooth), the code is accumulator bits [31:27].
- R5: With `wave_sel` = 2 (triangle), the code is accumulator bits [31:27] XOR five copies of a toggle bit. The toggle bit is 0 after reset and flips on every wrap, so one triangle period spans two wraps.
- R6: The accumulator takes in `wave_sel` only on a clock edge where it wraps, and while reset is held. At any other edge a change of `wave_sel` has no effect on the output.
- R7: `dac_code` after clock edge n is the code for the accumulator, toggle and mode state that existed after edge n-2.
- R8: While `rst` is high at a clock edge, the accumulator and the toggle bit clear to 0, and `wrap` and `dac_code` both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ftw | input | 32 | Frequency tuning word |
| wave_sel | input | 2 | Waveform: 0 sine, 1 sawtooth, 2 triangle, 3 sawtooth |
| dac_code | output | 5 | Registered unsigned DAC code |
| wrap | output | 1 | One-clock accumulator carry strobe |

## Verification
- **Slow tuning word.** A step of 2^24 sweeps every sine table entry in turn, which exposes any table or rounding error.
- **Coarse tuning word.** A step of 2^27 gives short, predictable periods. In sawtooth mode it separates a rising ramp from a folded one. In triangle mode it shows whether the fold follows the toggle bit.
- **Extreme tuning words.** A word of 0 must produce no strobes, and 2^31 must produce a strobe on alternate cycles. Together they show whether the strobe follows the carry.
- **Changes and random runs.** Mode changes are made between wraps, to tell sampling at the wrap apart from immediate switching. Seeded random words and selects, compared against a cycle model, catch latency and ordering mistakes that the directed runs might miss.

// File: rtl/dds_wavegen.sv
module dds_wavegen #(
  parameter int ACC_W = 32,
  parameter int IDX_W = 8,
  parameter int OUT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw,
  input  logic [1:0]       wave_sel,
  output logic [OUT_W-1:0] dac_code,
  output logic             wrap
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] W_SINE = 2'd0;
  localparam logic [1:0] W_SAW  = 2'd1;
  localparam logic [1:0] W_TRI  = 2'd2;

  function automatic logic [OUT_W-1:0] sine_code(input int k);
    real half, v;
    int  r;
    half = ((2.0 ** OUT_W) - 1.0) / 2.0;
    v    = half + half * $sin(2.0 * 3.14159265358979 * k / DEPTH);
    r    = $rtoi(v + 0.5);
    if (r < 0) r = 0;
    if (r > (1 << OUT_W) - 1) r = (1 << OUT_W) - 1;
    return OUT_W'(r);
  endfunction

  logic [OUT_W-1:0] rom [DEPTH];
  initial begin
    for (int k = 0; k < DEPTH; k++) rom[k] = sine_code(k);
  end

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic             tog;
  logic [1:0]       mode_q, p_mode;
  logic [IDX_W-1:0] phase, p_idx;

  assign sum   = {1'b0, acc} + {1'b0, ftw};
  assign phase = acc[ACC_W-1 -: IDX_W];

  // accumulator, wrap strobe, triangle toggle, mode latch (R1 R2 R5 R6 R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      wrap   <= 1'b0;
      tog    <= 1'b0;
      mode_q <= wave_sel;
    end else begin
      acc  <= sum[ACC_W-1:0];
      wrap <= sum[ACC_W];
      tog  <= tog ^ sum[ACC_W];
      if (sum[ACC_W]) mode_q <= wave_sel;
    end
  end

  // stage 1: fold phase for triangle (R5 R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      p_idx  <= '0;
      p_mode <= wave_sel;
    end else begin
      p_idx  <= (mode_q == W_TRI) ? (phase ^ {IDX_W{tog}}) : phase;
      p_mode <= mode_q;
    end
  end

  // stage 2: table or direct bits (R3 R4 R7)
  always_ff @(posedge clk) begin
    if (rst) dac_code <= '0;
    else     dac_code <= (p_mode == W_SINE) ? rom[p_idx] : p_idx[IDX_W-1 -: OUT_W];
  end

  assert_wrap_is_carry_R2: assert property (@(posedge clk) disable iff (rst)
    wrap == (acc < $past(acc)));

  assert_mode_only_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |-> $stable(mode_q));

  assert_toggle_only_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !wrap |-> $stable(tog));

  assert_saw_latency_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q, 2) == W_SAW) |-> dac_code == $past(acc[ACC_W-1 -: OUT_W], 2));

  assert_tri_fold_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q, 2) == W_TRI) |->
      dac_code == ($past(acc[ACC_W-1 -: OUT_W], 2) ^ {OUT_W{$past(tog, 2)}}));
endmodule

// File: tb/test_dds_wavegen.sv
module test_dds_wavegen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ftw = '0;
  logic [1:0]  sel = '0;
  logic [4:0]  dac;
  logic        wrap;

  dds_wavegen i_dds_wavegen (
    .clk(clk), .rst(rst), .ftw(ftw), .wave_sel(sel), .dac_code(dac), .wrap(wrap)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_acc;
  logic        m_tog;
  logic [1:0]  m_mode;
  logic [4:0]  q1;
  logic [1:0]  q1_mode;
  logic [1:0]  exp_mode;
  logic [4:0]  exp_dac;
  logic        exp_wrap;
  int          wraps;

  function automatic logic [4:0] sine_exp(input int k);
    real v;
    int  r;
    v = 15.5 + 15.5 * $sin(2.0 * 3.14159265358979 * k / 256.0);
    r = $rtoi(v + 0.5);
    if (r < 0) r = 0;
    if (r > 31) r = 31;
    return 5'(r);
  endfunction

  function automatic logic [4:0] code_exp(input logic [31:0] a, input logic t, input logic [1:0] m);
    if (m == 2'd0) return sine_exp(int'(a[31:24]));
    if (m == 2'd2) return a[31:27] ^ {5{t}};
    return a[31:27];
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    if (m == 2'd0) return "R3/R7";
    if (m == 2'd2) return "R5/R7";
    return "R4/R7";
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst = 1'b1; sel = s; ftw = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R8 dac", int'(dac), 0);
    check("R8 wrap", int'(wrap), 0);
    m_acc = '0; m_tog = 1'b0; m_mode = s;
    q1 = code_exp('0, 1'b0, s); q1_mode = s;
    rst = 1'b0;
  endtask

  task automatic step(input logic [31:0] f, input logic [1:0] s);
    logic [32:0] nx;
    ftw = f; sel = s;
    @(posedge clk);
    exp_dac = q1; exp_mode = q1_mode;
    q1 = code_exp(m_acc, m_tog, m_mode); q1_mode = m_mode;
    nx = {1'b0, m_acc} + {1'b0, f};
    m_acc = nx[31:0]; exp_wrap = nx[32];
    m_tog = m_tog ^ nx[32];
    if (nx[32]) m_mode = s;
    @(negedge clk);
    check(tag_of(exp_mode), int'(dac), int'(exp_dac));
    check("R2", int'(wrap), int'(exp_wrap));
    if (wrap) wraps++;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2025));
    @(negedge clk);

    // R1: sawtooth ramp
    do_reset(2'd1);
    for (int k = 1; k <= 10; k++) step(32'h0800_0000, 2'd1);
    check("R1 ramp", int'(dac), 8);

    // R3: sine sweep, one table entry per clock
    do_reset(2'd0);
    step(32'h0100_0000, 2'd0);
    step(32'h0100_0000, 2'd0);
    check("R3 k0", int'(dac), 16);
    for (int k = 3; k <= 66; k++) step(32'h0100_0000, 2'd0);
    check("R3 k64", int'(dac), 31);
    for (int k = 67; k <= 194; k++) step(32'h0100_0000, 2'd0);
    check("R3 k192", int'(dac), 0);
    for (int k = 195; k <= 300; k++) step(32'h0100_0000, 2'd0);

    // R5: triangle folds on the second wrap
    do_reset(2'd2);
    for (int k = 1; k <= 42; k++) step(32'h0800_0000, 2'd2);
    check("R5 fold", int'(dac), 23);

    // R6: select change between wraps waits for the wrap
    do_reset(2'd0);
    for (int k = 1; k <= 5; k++) step(32'h0800_0000, 2'd0);
    for (int k = 6; k <= 20; k++) step(32'h0800_0000, 2'd1);
    check("R6 held", int'(dac), int'(sine_exp(144)));
    for (int k = 21; k <= 40; k++) step(32'h0800_0000, 2'd1);
    check("R6 switched", int'(dac), 6);

    // R2: zero word, half-range word
    do_reset(2'd1);
    wraps = 0;
    for (int k = 0; k < 50; k++) step(32'h0, 2'd1);
    check("R2 none", wraps, 0);
    wraps = 0;
    for (int k = 0; k < 20; k++) step(32'h8000_0000, 2'd1);
    check("R2 alt", wraps, 10);

    // random runs with mid-run resets (R8)
    for (int b = 0; b < 12; b++) begin
      logic [31:0] f;
      do_reset(2'($urandom));
      f = $urandom >> ($urandom % 12);
      for (int k = 0; k < 300; k++) begin
        if ($urandom % 40 == 0) f = $urandom >> ($urandom % 12);
        step(f, 2'($urandom));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule